// File: doc/BRIEF.md
# Multiplexed HH:MM Seven-Segment Driver

This block turns a binary hour (0 to 23) and a binary minute (0 to 59) into an HH:MM image on a four-digit, common-anode seven-segment display. The display is time-multiplexed. All four digits share one set of segment lines, and only one digit enable is active at a time. A scan timer divides the system clock down to the per-digit refresh rate and steps the digit index. At each step, the hour and minute values are split into tens and units digits and decoded to segment patterns. A separate flag drives the decimal point of the second digit, so that it can serve as a colon, for example to show whether timekeeping is running.

The scan has no enable input. It keeps refreshing whatever values sit on its inputs, so the image stays lit and steady while the timekeeping core that feeds it is paused. The inputs are captured only when the scan moves to another digit. An update that arrives partway through a digit period therefore never changes the pattern shown for that digit.

Top module: `hhmm_seg_driver`

## Requirements
- R1: At most one bit of `an_o` is low at any time. Bit k of `an_o` is the active-low enable of digit index k.
- R2: A scan tick occurs once every DIV = CLK_HZ/SCAN_HZ clock cycles, and it never stops while the block is out of reset. Each tick after the first advances the digit index by one, wrapping from 3 to 0. SCAN_HZ defaults to 4000, which is within the 1 kHz to 10 kHz range.
- R3: Digit index 3 shows the hour tens, index 2 the hour units, index 1 the minute tens and index 0 the minute units.
- R4: Each value is split into a tens digit equal to value/10 and a units digit equal to value%10.
- R5: `seg_o` is active-low, with bit order {g,f,e,d,c,b,a}. The active-high patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex). The output is the bitwise inverse of that pattern.
- R6: `dp_o` (active-low) is low only while digit index 2 is enabled and the captured `colon_i` is 1.
- R7: While `rst_ni` is low, and after it rises until the first tick: `an_o` = 4'hF, `seg_o` = 7'h7F, `dp_o` = 1, and the index is 0. The first tick comes DIV cycles after reset is released. It enables digit 0 without advancing the index.
- R8: `hour_i`, `min_i` and `colon_i` are captured only on the clock edge of a tick. Between ticks, changes on these inputs leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hour_i | input | 5 | Binary hour, 0 to 23 |
| min_i | input | 6 | Binary minute, 0 to 59 |
| colon_i | input | 1 | Colon indicator request, shown on digit 2's decimal point |
| an_o | output | 4 | Active-low digit enables, bit k = digit index k |
| seg_o | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| dp_o | output | 1 | Active-low decimal point |

## Verification
Two functions can fall in the same cycle: a change of the hour, minute or colon input, and the scan tick that captures those inputs and moves to the next digit. The bench provokes this by changing the inputs at hold lengths that vary from 1 to 13 cycles against a scan period of 10 cycles, so many changes land on the negative edge just before a tick edge. Other changes land in the middle of a digit period. A behavioural model captures the inputs only on its own tick count, so the outputs are judged against it on every cycle. This shows that a change made just before a tick appears on the new digit, and that a change made mid-period stays invisible until the next tick.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
  localparam int unsigned NDIG  = 4;
  localparam int unsigned IDX_W = 2;
  typedef logic [IDX_W-1:0] dig_idx_t;
  typedef logic [3:0]       bcd_t;
  typedef logic [6:0]       seg_t;      // {g,f,e,d,c,b,a}
  localparam seg_t SEG_OFF = 7'h7F;     // active-low blank
endpackage

// File: rtl/seg_scan_timer.sv
module seg_scan_timer #(
  parameter int unsigned DIV = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/seg_bcd_split.sv
module seg_bcd_split
  import segdisp_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] val_i,
  output bcd_t         tens_o,
  output bcd_t         units_o
);
  // compare-subtract: input is below 100, so 9 compares suffice
  always_comb begin
    tens_o = '0;
    for (int k = 1; k <= 9; k++) begin
      if (int'(val_i) >= 10 * k) tens_o = 4'(k);
    end
    units_o = 4'(int'(val_i) - 10 * int'(tens_o));
  end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import segdisp_pkg::*;
(
  input  bcd_t digit_i,
  output seg_t seg_no
);
  seg_t pat;
  always_comb begin
    unique case (digit_i)
      4'd0:    pat = 7'h3F;
      4'd1:    pat = 7'h06;
      4'd2:    pat = 7'h5B;
      4'd3:    pat = 7'h4F;
      4'd4:    pat = 7'h66;
      4'd5:    pat = 7'h6D;
      4'd6:    pat = 7'h7D;
      4'd7:    pat = 7'h07;
      4'd8:    pat = 7'h7F;
      4'd9:    pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    seg_no = ~pat;
  end
endmodule

// File: rtl/hhmm_seg_driver.sv
module hhmm_seg_driver
  import segdisp_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned SCAN_HZ = 4000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [4:0] hour_i,
  input  logic [5:0] min_i,
  input  logic       colon_i,
  output logic [3:0] an_o,
  output logic [6:0] seg_o,
  output logic       dp_o
);
  localparam int unsigned DIV = CLK_HZ / SCAN_HZ;
  localparam dig_idx_t    COLON_IDX = 2'd2;

  logic     scan_tick;
  logic     en_q;
  dig_idx_t idx_q;
  logic [4:0] hr_q;
  logic [5:0] mn_q;
  logic       col_q;

  seg_scan_timer #(.DIV(DIV)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(scan_tick)
  );

  // inputs captured only when the digit changes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      idx_q <= '0;
      hr_q  <= '0;
      mn_q  <= '0;
      col_q <= 1'b0;
    end else if (scan_tick) begin
      en_q  <= 1'b1;
      idx_q <= en_q ? idx_q + 1'b1 : idx_q;
      hr_q  <= hour_i;
      mn_q  <= min_i;
      col_q <= colon_i;
    end
  end

  bcd_t d_bcd [NDIG];

  seg_bcd_split #(.W(5)) u_split_hr (
    .val_i  (hr_q),
    .tens_o (d_bcd[3]),
    .units_o(d_bcd[2])
  );

  seg_bcd_split #(.W(6)) u_split_mn (
    .val_i  (mn_q),
    .tens_o (d_bcd[1]),
    .units_o(d_bcd[0])
  );

  bcd_t cur_bcd;
  seg_t cur_seg;
  assign cur_bcd = d_bcd[idx_q];

  seg_decoder u_dec (
    .digit_i(cur_bcd),
    .seg_no (cur_seg)
  );

  logic [NDIG-1:0] an_sel;
  generate
    for (genvar g = 0; g < NDIG; g++) begin : g_an
      assign an_sel[g] = ~(idx_q == dig_idx_t'(g));
    end
  endgenerate

  always_comb begin
    if (en_q) begin
      an_o  = an_sel;
      seg_o = cur_seg;
      dp_o  = ~(col_q && (idx_q == COLON_IDX));
    end else begin
      an_o  = '1;
      seg_o = SEG_OFF;
      dp_o  = 1'b1;
    end
  end
endmodule

// File: rtl/hhmm_seg_driver_chk.sv
module hhmm_seg_driver_chk #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned SCAN_HZ = 4000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [3:0] an_o,
  input logic [6:0] seg_o,
  input logic       dp_o
);
  localparam int unsigned DIV = CLK_HZ / SCAN_HZ;

  logic [3:0] an_prev;
  int unsigned gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      an_prev <= 4'hF;
      gap_q   <= 0;
    end else begin
      an_prev <= an_o;
      gap_q   <= tick_i ? 0 : gap_q + 1;
    end
  end

  AST_ONE_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~an_o) <= 1); // R1

  AST_ROTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_prev != 4'hF && an_o != an_prev) |-> an_o == {an_prev[2:0], an_prev[3]}); // R2

  AST_TICK_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> gap_q == DIV - 1); // R2

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < DIV); // R2

  AST_DP_DIGIT2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dp_o |-> an_o == 4'b1011); // R6

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(an_o) && $stable(seg_o) && $stable(dp_o))); // R8

  AST_DARK_SEGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_o == 4'hF |-> (seg_o == 7'h7F && dp_o)); // R7
endmodule

bind hhmm_seg_driver hhmm_seg_driver_chk #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tick_i(scan_tick),
  .an_o  (an_o),
  .seg_o (seg_o),
  .dp_o  (dp_o)
);

// File: tb/hhmm_seg_driver_bench.sv
module hhmm_seg_driver_bench;
  localparam int PERIOD  = 10;
  localparam int CLK_HZ  = 1000;
  localparam int SCAN_HZ = 100;
  localparam int DIV     = CLK_HZ / SCAN_HZ;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] hour = '0;
  logic [5:0] minute = '0;
  logic       colon = 1'b0;
  logic [3:0] an;
  logic [6:0] seg;
  logic       dp;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  hhmm_seg_driver #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ)) u_hhmm_seg_driver (
    .clk_i(clk), .rst_ni(rst_ni), .hour_i(hour), .min_i(minute),
    .colon_i(colon), .an_o(an), .seg_o(seg), .dp_o(dp)
  );

  // behavioural reference
  int m_cnt, m_idx, m_hr, m_mn;
  bit m_en, m_col;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_en = 0; m_idx = 0; m_hr = 0; m_mn = 0; m_col = 0;
    end else begin
      m_cnt++;
      if (m_cnt == DIV) begin
        m_cnt = 0;
        if (m_en) m_idx = (m_idx + 1) % 4;
        m_en  = 1;
        m_hr  = hour;
        m_mn  = minute;
        m_col = colon;
      end
    end
  end

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // compare every cycle, a quarter period after the rising edge
  always begin
    @(posedge clk);
    #(PERIOD/4);
    if (!done) begin
      logic [3:0] e_an;
      logic [6:0] e_seg;
      logic       e_dp;
      int dval;
      if (!m_en) begin
        e_an = 4'hF; e_seg = 7'h7F; e_dp = 1'b1;
      end else begin
        e_an = ~(4'b0001 << m_idx);
        case (m_idx)
          3: dval = m_hr / 10;
          2: dval = m_hr % 10;
          1: dval = m_mn / 10;
          default: dval = m_mn % 10;
        endcase
        e_seg = ~pat(dval);
        e_dp  = !(m_col && m_idx == 2);
      end
      if (!rst_ni || !m_en) check("R7 an", an, e_an);
      else                  check("R1/R2 an", an, e_an);
      check("R3/R4/R5/R8 seg", seg, e_seg);
      check("R6 dp", dp, e_dp);
    end
  end

  task automatic apply(input int h, input int m, input bit c, input int hold);
    @(negedge clk);
    hour = 5'(h); minute = 6'(m); colon = c;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    done = 1;
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R7: dark until first tick
    repeat (DIV - 2) @(negedge clk);
    check("R7 dark before tick", an, 4'hF);
    // boundaries
    apply(23, 59, 1, 45);
    apply(0, 0, 0, 45);
    apply(9, 9, 1, 45);
    apply(10, 50, 1, 45);
    apply(19, 40, 0, 45);
    // mixed hold lengths, many changes landing next to a tick (R8)
    for (int i = 0; i < 120; i++)
      apply((i * 7) % 24, (i * 13) % 60, i[0], (i % 13) + 1);
    // mid-run reset (R7) then resume
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    apply(12, 34, 1, 60);
    for (int i = 0; i < 40; i++)
      apply((i * 5) % 24, (i * 11 + 3) % 60, ~i[0], (i % 7) + 3);
    repeat (5) @(negedge clk);
    done = 1;
    report();
  end
endmodule